// File: doc/BRIEF.md
# Non-Blocking Load Miss Tracker

This block lets an in-order pipeline retire a load whose data cache lookup missed, without waiting for the data. The load has already passed its translation and permission check when it reaches the block, so it cannot fault afterwards. The block stores the load's word address and destination register in one of a small set of tracking slots and marks that register as owed in a scoreboard. From then on, only instructions that read that register are held back. Other instructions keep flowing, stores included.

The issue stage presents up to two source register numbers and receives a single stall flag. A fill return carries a 64-byte line address and the whole line. Every slot waiting on that line extracts its word in the same cycle and presents a register write. The slot and its scoreboard bit are released at the following clock edge. The line addresses of all occupied slots are exported, so that store-commit logic can test a store for overlap against pending misses.

Top module: `load_miss_tracker`

## Requirements
- R1: After reset every slot is empty, no register is pending, `alloc_ready` is 1 and `issue_stall` is 0.
- R2: When `alloc_valid` and `alloc_ready` are both 1 at a clock edge, the lowest-numbered empty slot captures the load. From the next cycle its `pend_valid` bit is 1 and its `pend_line` field holds the address bits above the 6-bit line offset. Load addresses are word aligned (bits 1:0 zero).
- R3: From the cycle after a load is accepted, `issue_stall` is 1 whenever `src_a` or `src_b` equals its destination register. This holds until the fill for that load has been presented.
- R4: A query on registers that are not pending gives `issue_stall` 0, whatever else is outstanding.
- R5: With all 4 slots occupied, `alloc_ready` is 0 and a request has no effect on the slots.
- R6: When `alloc_rd` is already pending, `alloc_ready` is 0 even if a slot is free.
- R7: In a cycle with `fill_valid`, every occupied slot whose line equals `fill_line` raises its `wb_valid` bit. Its `wb_rd` field holds its register, and its `wb_data` field holds line word k, where k is address bits 5:2 and word k occupies bits 32k+31..32k of `fill_data`.
- R8: At the edge that ends such a fill cycle, the matching slots empty and their registers stop being pending. Slots on other lines are unchanged.
- R9: Acceptance is judged on the state before the edge. A load accepted in a fill cycle is not completed by that fill, even when it targets the same line. A register that the same fill is releasing is still refused.
- R10: Up to 4 misses are outstanding at once and complete independently, in any order of fills.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Missed load offered for tracking |
| alloc_addr | input | 32 | Word address of the load |
| alloc_rd | input | 5 | Destination register of the load |
| alloc_ready | output | 1 | Offered load is accepted this cycle |
| src_a | input | 5 | First source register of the issuing instruction |
| src_b | input | 5 | Second source register of the issuing instruction |
| issue_stall | output | 1 | A source register is still owed by a miss |
| fill_valid | input | 1 | Line return present |
| fill_line | input | 26 | Line address of the return |
| fill_data | input | 512 | Full line contents |
| wb_valid | output | 4 | Per-slot register write strobe |
| wb_rd | output | 20 | Per-slot destination register, 5 bits per slot |
| wb_data | output | 128 | Per-slot loaded word, 32 bits per slot |
| pend_valid | output | 4 | Per-slot occupied flag |
| pend_line | output | 104 | Per-slot line address, 26 bits per slot |

## Verification
`alloc_ready`, `issue_stall` and the write-back strobes are combinational on the present inputs and the registered state. They are therefore due in the same cycle as the stimulus. Slot occupancy, `pend_line` and the pending status of a register change one edge after an accepted load or a fill. The bench drives inputs just after the falling edge and compares all outputs against its model a quarter period later. It then advances the model past the next rising edge, so a same-cycle result and a next-cycle result are each checked in the cycle they are due.

// File: rtl/lmt_pkg.sv
package lmt_pkg;
  localparam int unsigned DEF_ADDR_W     = 32;
  localparam int unsigned DEF_DATA_W     = 32;
  localparam int unsigned DEF_LINE_BYTES = 64;
  localparam int unsigned DEF_REGS       = 32;
  localparam int unsigned DEF_SLOTS      = 4;
endpackage

// File: rtl/lmt_pick.sv
module lmt_pick #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] free_vec,
  output logic [N-1:0] grant,
  output logic         any_free
);
  always_comb begin
    grant = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (free_vec[i]) grant = N'(1) << i;
    end
  end

  assign any_free = |free_vec;

  always_comb begin
    assert_grant_onehot_R2: assert ($onehot0(grant));
  end
endmodule

// File: rtl/lmt_entry.sv
module lmt_entry #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned REG_W      = 5,
  parameter int unsigned LINE_BYTES = 64
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        alloc_we,
  input  logic [ADDR_W-1:0]           alloc_addr,
  input  logic [REG_W-1:0]            alloc_rd,
  input  logic                        fill_valid,
  input  logic [ADDR_W-$clog2(LINE_BYTES)-1:0] fill_line,
  input  logic [LINE_BYTES*8-1:0]     fill_data,
  output logic                        busy,
  output logic [ADDR_W-$clog2(LINE_BYTES)-1:0] line,
  output logic [REG_W-1:0]            rd,
  output logic                        wb_fire,
  output logic [DATA_W-1:0]           wb_word
);
  localparam int unsigned OFS_W  = $clog2(LINE_BYTES);
  localparam int unsigned WB_W   = $clog2(DATA_W / 8);
  localparam int unsigned WIDX_W = OFS_W - WB_W;
  localparam int unsigned LA_W   = ADDR_W - OFS_W;

  function automatic logic [LA_W-1:0] line_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:OFS_W];
  endfunction

  function automatic logic [WIDX_W-1:0] word_of(input logic [ADDR_W-1:0] a);
    return a[OFS_W-1:WB_W];
  endfunction

  function automatic logic [DATA_W-1:0] pick_word(input logic [LINE_BYTES*8-1:0] d,
                                                  input logic [WIDX_W-1:0] k);
    return d[k*DATA_W +: DATA_W];
  endfunction

  logic [ADDR_W-1:0] addr_q;
  logic              line_hit;

  assign line     = line_of(addr_q);
  assign line_hit = busy && fill_valid && (line == fill_line);
  assign wb_fire  = line_hit;
  assign wb_word  = pick_word(fill_data, word_of(addr_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      addr_q <= '0;
      rd     <= '0;
    end else if (line_hit) begin
      busy <= 1'b0;
    end else if (alloc_we) begin
      busy   <= 1'b1;
      addr_q <= alloc_addr;
      rd     <= alloc_rd;
    end
  end

  assert_alloc_into_free_R2: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_we |-> (!busy && alloc_addr[WB_W-1:0] == '0));

  assert_fill_releases_R8: assert property (@(posedge clk) disable iff (!rst_n)
    line_hit |=> !busy);

  assert_unrelated_fill_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !line_hit) |=> (busy && $stable(rd)));
endmodule

// File: rtl/lmt_scoreboard.sv
module lmt_scoreboard #(
  parameter int unsigned REGS = 32,
  parameter int unsigned N    = 4,
  localparam int unsigned REG_W = $clog2(REGS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               set_en,
  input  logic [REG_W-1:0]   set_rd,
  input  logic [N-1:0]       clr_en,
  input  logic [N*REG_W-1:0] clr_rd,
  input  logic [REG_W-1:0]   q_a,
  input  logic [REG_W-1:0]   q_b,
  input  logic [REG_W-1:0]   q_c,
  output logic [REGS-1:0]    pend,
  output logic               busy_a,
  output logic               busy_b,
  output logic               busy_c
);
  logic [REGS-1:0] pend_nxt;

  always_comb begin
    pend_nxt = pend;
    for (int i = 0; i < N; i++) begin
      if (clr_en[i]) pend_nxt[clr_rd[i*REG_W +: REG_W]] = 1'b0;
    end
    if (set_en) pend_nxt[set_rd] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pend <= '0;
    else        pend <= pend_nxt;
  end

  assign busy_a = pend[q_a];
  assign busy_b = pend[q_b];
  assign busy_c = pend[q_c];

  assert_no_double_owner_R6: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |-> !pend[set_rd]);

  generate
    for (genvar g = 0; g < N; g++) begin : g_clr_chk
      assert_clear_only_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en[g] |-> pend[clr_rd[g*REG_W +: REG_W]]);
      assert_clear_takes_effect_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en[g] |=> !pend[$past(clr_rd[g*REG_W +: REG_W])]);
    end
  endgenerate
endmodule

// File: rtl/load_miss_tracker.sv
module load_miss_tracker
  import lmt_pkg::*;
#(
  parameter int unsigned ADDR_W     = DEF_ADDR_W,
  parameter int unsigned DATA_W     = DEF_DATA_W,
  parameter int unsigned LINE_BYTES = DEF_LINE_BYTES,
  parameter int unsigned REGS       = DEF_REGS,
  parameter int unsigned SLOTS      = DEF_SLOTS,
  localparam int unsigned REG_W     = $clog2(REGS),
  localparam int unsigned LA_W      = ADDR_W - $clog2(LINE_BYTES)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    alloc_valid,
  input  logic [ADDR_W-1:0]       alloc_addr,
  input  logic [REG_W-1:0]        alloc_rd,
  output logic                    alloc_ready,
  input  logic [REG_W-1:0]        src_a,
  input  logic [REG_W-1:0]        src_b,
  output logic                    issue_stall,
  input  logic                    fill_valid,
  input  logic [LA_W-1:0]         fill_line,
  input  logic [LINE_BYTES*8-1:0] fill_data,
  output logic [SLOTS-1:0]        wb_valid,
  output logic [SLOTS*REG_W-1:0]  wb_rd,
  output logic [SLOTS*DATA_W-1:0] wb_data,
  output logic [SLOTS-1:0]        pend_valid,
  output logic [SLOTS*LA_W-1:0]   pend_line
);
  logic [SLOTS-1:0] slot_busy;
  logic [SLOTS-1:0] slot_grant;
  logic [SLOTS-1:0] slot_we;
  logic             any_free;
  logic             rd_owed;
  logic             alloc_fire;
  logic             busy_a;
  logic             busy_b;
  logic [REGS-1:0]  sb_pend;

  lmt_pick #(.N(SLOTS)) u_pick (
    .free_vec (~slot_busy),
    .grant    (slot_grant),
    .any_free (any_free)
  );

  assign alloc_ready = any_free && !rd_owed;
  assign alloc_fire  = alloc_valid && alloc_ready;
  assign slot_we     = alloc_fire ? slot_grant : '0;

  generate
    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
      lmt_entry #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_W(REG_W), .LINE_BYTES(LINE_BYTES)
      ) u_entry (
        .clk        (clk),
        .rst_n      (rst_n),
        .alloc_we   (slot_we[g]),
        .alloc_addr (alloc_addr),
        .alloc_rd   (alloc_rd),
        .fill_valid (fill_valid),
        .fill_line  (fill_line),
        .fill_data  (fill_data),
        .busy       (slot_busy[g]),
        .line       (pend_line[g*LA_W +: LA_W]),
        .rd         (wb_rd[g*REG_W +: REG_W]),
        .wb_fire    (wb_valid[g]),
        .wb_word    (wb_data[g*DATA_W +: DATA_W])
      );

      assert_slot_reg_owed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        slot_busy[g] |-> sb_pend[wb_rd[g*REG_W +: REG_W]]);
    end
  endgenerate

  assign pend_valid = slot_busy;

  lmt_scoreboard #(.REGS(REGS), .N(SLOTS)) u_sb (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_en (alloc_fire),
    .set_rd (alloc_rd),
    .clr_en (wb_valid),
    .clr_rd (wb_rd),
    .q_a    (src_a),
    .q_b    (src_b),
    .q_c    (alloc_rd),
    .pend   (sb_pend),
    .busy_a (busy_a),
    .busy_b (busy_b),
    .busy_c (rd_owed)
  );

  assign issue_stall = busy_a || busy_b;

  assert_owed_count_matches_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(sb_pend) == $countones(slot_busy));

  assert_accept_marks_owed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_fire |=> sb_pend[$past(alloc_rd)]);

  assert_full_refuses_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (&slot_busy) |=> $stable(pend_line) || !(&$past(slot_busy)) || $past(fill_valid));
endmodule

// File: tb/tb_load_miss_tracker.sv
module tb_load_miss_tracker;
  localparam int N = 4;
  localparam int RW = 5;
  localparam int LA = 26;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic alloc_valid = 1'b0;
  logic [31:0] alloc_addr = '0;
  logic [RW-1:0] alloc_rd = '0;
  logic alloc_ready;
  logic [RW-1:0] src_a = '0;
  logic [RW-1:0] src_b = '0;
  logic issue_stall;
  logic fill_valid = 1'b0;
  logic [LA-1:0] fill_line = '0;
  logic [511:0] fill_data = '0;
  logic [N-1:0] wb_valid;
  logic [N*RW-1:0] wb_rd;
  logic [N*32-1:0] wb_data;
  logic [N-1:0] pend_valid;
  logic [N*LA-1:0] pend_line;

  always #10 clk = ~clk;

  load_miss_tracker dut (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_addr(alloc_addr), .alloc_rd(alloc_rd),
    .alloc_ready(alloc_ready), .src_a(src_a), .src_b(src_b), .issue_stall(issue_stall),
    .fill_valid(fill_valid), .fill_line(fill_line), .fill_data(fill_data),
    .wb_valid(wb_valid), .wb_rd(wb_rd), .wb_data(wb_data),
    .pend_valid(pend_valid), .pend_line(pend_line)
  );

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  // reference model state
  bit          m_busy [N];
  logic [31:0] m_addr [N];
  int          m_rd   [N];
  bit          m_owed [32];

  task automatic check(string req, logic [511:0] act, logic [511:0] exp, string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [511:0] mk_line(int seed);
    logic [511:0] d;
    for (int k = 0; k < 16; k++) d[k*32 +: 32] = (seed * 32'h0100_0193) ^ (k * 32'h0000_9E37) ^ 32'h5A00_0000;
    return d;
  endfunction

  // compare all outputs with the model, then advance the model past the rising edge
  task automatic step();
    bit exp_ready, exp_stall, any_free, exp_wb;
    int first_free;
    #5;
    any_free = 0;
    first_free = -1;
    for (int i = 0; i < N; i++) if (!m_busy[i] && first_free < 0) first_free = i;
    any_free = (first_free >= 0);
    exp_ready = any_free && !m_owed[alloc_rd];
    if (!any_free) check("R5", alloc_ready, exp_ready, "alloc_ready when full");
    else if (m_owed[alloc_rd]) check("R6", alloc_ready, exp_ready, "alloc_ready on owed reg");
    else check("R1", alloc_ready, exp_ready, "alloc_ready idle/free");
    exp_stall = m_owed[src_a] || m_owed[src_b];
    if (exp_stall) check("R3", issue_stall, exp_stall, "issue_stall");
    else check("R4", issue_stall, exp_stall, "issue_stall");
    for (int i = 0; i < N; i++) begin
      check("R2", pend_valid[i], m_busy[i], $sformatf("pend_valid[%0d]", i));
      if (m_busy[i]) check("R2", pend_line[i*LA +: LA], m_addr[i][31:6], $sformatf("pend_line[%0d]", i));
      exp_wb = m_busy[i] && fill_valid && (m_addr[i][31:6] == fill_line);
      check("R7", wb_valid[i], exp_wb, $sformatf("wb_valid[%0d]", i));
      if (exp_wb) begin
        check("R7", wb_rd[i*RW +: RW], m_rd[i], $sformatf("wb_rd[%0d]", i));
        check("R7", wb_data[i*32 +: 32], fill_data[m_addr[i][5:2]*32 +: 32], $sformatf("wb_data[%0d]", i));
      end
    end
    // R8: release matching slots; R9: allocation judged on the pre-edge state
    for (int i = 0; i < N; i++) begin
      if (m_busy[i] && fill_valid && (m_addr[i][31:6] == fill_line)) begin
        m_busy[i] = 0;
        m_owed[m_rd[i]] = 0;
      end
    end
    if (alloc_valid && exp_ready) begin
      m_busy[first_free] = 1;
      m_addr[first_free] = alloc_addr;
      m_rd[first_free] = alloc_rd;
      m_owed[alloc_rd] = 1;
    end
    @(negedge clk);
  endtask

  task automatic cyc(bit av, logic [31:0] aa, int ar, int qa, int qb, bit fv, logic [31:0] fa, int seed);
    alloc_valid = av; alloc_addr = aa; alloc_rd = RW'(ar);
    src_a = RW'(qa); src_b = RW'(qb);
    fill_valid = fv; fill_line = fa[31:6]; fill_data = mk_line(seed);
    step();
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin m_busy[i] = 0; m_addr[i] = '0; m_rd[i] = 0; end
    for (int r = 0; r < 32; r++) m_owed[r] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    cyc(0, 0, 0, 1, 2, 0, 0, 0);
    // R2: first miss, then R3/R4 queries
    cyc(1, 32'h0000_1048, 5, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 5, 6, 0, 0, 0);
    cyc(0, 0, 0, 6, 7, 0, 0, 0);
    // R6: owed destination refused while slots free
    cyc(1, 32'h0000_5000, 5, 0, 0, 0, 0, 0);
    // R10: fill up all slots, two sharing line 0x41
    cyc(1, 32'h0000_1070, 7, 0, 7, 0, 0, 0);
    cyc(1, 32'h0000_2004, 9, 0, 0, 0, 0, 0);
    cyc(1, 32'h0000_3000, 11, 9, 11, 0, 0, 0);
    // R5: full, request ignored; pend vector checked next cycle
    cyc(1, 32'h0000_4000, 12, 12, 0, 0, 0, 0);
    cyc(0, 0, 0, 12, 11, 0, 0, 0);
    // R8: out-of-order fill of the last slot
    cyc(0, 0, 0, 11, 0, 1, 32'h0000_3000, 3);
    cyc(0, 0, 0, 11, 0, 0, 0, 0);
    // R7: one fill completes two slots
    cyc(0, 0, 0, 5, 7, 1, 32'h0000_1040, 7);
    cyc(0, 0, 0, 5, 7, 0, 0, 0);
    // R9: same-line allocation during a fill is not completed by it
    cyc(1, 32'h0000_2010, 13, 9, 13, 1, 32'h0000_2000, 9);
    cyc(0, 0, 0, 13, 9, 0, 0, 0);
    // R9: register being released in the same cycle is still refused
    cyc(1, 32'h0000_6000, 13, 0, 0, 1, 32'h0000_2000, 11);
    cyc(0, 0, 0, 13, 0, 0, 0, 0);
    // no match fill
    cyc(0, 0, 0, 0, 0, 1, 32'h0000_7000, 4);
    // mixed traffic
    for (int t = 0; t < 600; t++) begin
      logic [31:0] a;
      a = {20'h0, 6'h0, 6'h0} | ((32'h40 + ($urandom % 6)) << 6) | (($urandom % 16) << 2);
      cyc($urandom % 2, a, $urandom % 8, $urandom % 8, $urandom % 8,
          ($urandom % 4) == 0, (32'h40 + ($urandom % 6)) << 6, t);
    end
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule